// File: doc/BRIEF.md
# Three-Wire Codec Control Byte Transmitter

This block sends single bytes to an audio codec over a write-only three-wire control bus made of a mode line, a clock line and a data line. A host asserts `start_i` with a byte and a mode bit. The block takes both in, holds the bus clock high while the mode line settles for a programmable setup window, and then sends the eight bits lowest bit first. For each bit the clock drops for one half-period and rises for a second half-period, and the data line holds the same value for both. Once the last bit has gone out, the bus returns to its resting levels and `done_o` pulses for one cycle.

Every duration is a whole number of system clock cycles, set by the parameters `SETUP_CYCLES` and `HALF_CYCLES`. Both must be at least 1. The defaults suit a 250 MHz system clock: 48 setup cycles cover the 190 ns mode setup minimum. The control is a five-state machine:

- IDLE goes to SETUP on an accepted start.
- SETUP goes to CLK_LO when the setup window runs out.
- CLK_LO goes to CLK_HI when the half-period runs out.
- CLK_HI goes back to CLK_LO when more bits remain, or on to FINISH after the last bit.
- FINISH goes to IDLE after one cycle.

Top module: `ctlbus_byte_tx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the outputs are mode=1, clock=1, data=0, busy=0 and done=0.
- R2: Whenever busy is low, the bus holds its resting levels: mode=1, clock=1, data=0.
- R3: A start seen at a clock edge while the block is idle makes busy high from the next cycle. For the next SETUP_CYCLES cycles the mode line carries the requested mode bit, the clock stays high and the data line is 0.
- R4: The first falling edge of the bus clock comes exactly SETUP_CYCLES cycles after busy rises.
- R5: Each transfer sends exactly eight bits, bit 0 of the byte first and bit 7 last.
- R6: Each bit holds the clock low for HALF_CYCLES cycles and then high for HALF_CYCLES cycles, with the data line at the bit value throughout both halves.
- R7: In the cycle after the eighth high half-period, the bus is back at mode=1, clock=1, data=0.
- R8: done is high for exactly one cycle, the cycle in which the resting levels return. busy is still high in that cycle and low in the next one.
- R9: A start seen while busy is high, including the done cycle, is ignored. It neither restarts nor extends the current transfer.
- R10: The byte and mode bit are captured when start is accepted. Later changes on those inputs do not affect the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to send one byte; honoured only while idle |
| mode_i | input | 1 | Mode-line level for the transfer |
| byte_i | input | DATA_W | Byte to send |
| busy_o | output | 1 | High from the cycle after acceptance until the done cycle ends |
| done_o | output | 1 | One-cycle pulse when the transfer completes |
| bus_mode_o | output | 1 | Bus mode line |
| bus_clk_o | output | 1 | Bus clock line, resting high |
| bus_dat_o | output | 1 | Bus data line, resting low |

## Verification
A wrong state or timer value changes the bus waveform within one half-period. A clock edge arrives a cycle early or late, or the data line changes while the clock is high, and the cycle-by-cycle comparison catches it at the next sample. A bit index that is off by one, or a shift register that reloads from the live input, puts the wrong data level on the line in the first affected bit window. A stuck or skipped FINISH state shows within one cycle as a missing done pulse, or as busy staying high after the resting levels return.

// File: rtl/ctlbus_tx_pkg.sv
package ctlbus_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_FINISH
    } tx_state_e;

endpackage

// File: rtl/ctlbus_tx_timer.sv
// Down-counter that measures one timed bus phase.
module ctlbus_tx_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/ctlbus_tx_shifter.sv
// Captures the byte and mode bit, then presents bits lowest first.
module ctlbus_tx_shifter #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [NBITS-1:0] byte_in,
    input  logic             mode_in,
    input  logic             step,
    output logic             cur_bit,
    output logic             mode_q,
    output logic             last_bit
);

    localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1;

    logic [NBITS-1:0] sh;
    logic [IW-1:0]    idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh     <= '0;
            idx    <= '0;
            mode_q <= 1'b1;
        end else if (capture) begin
            sh     <= byte_in;
            idx    <= '0;
            mode_q <= mode_in;
        end else if (step) begin
            sh     <= sh >> 1;
            idx    <= idx + IW'(1);
        end
    end

    assign cur_bit  = sh[0];
    assign last_bit = (idx == IW'(NBITS - 1));

endmodule

// File: rtl/ctlbus_tx_fsm.sv
// Phase sequencer and bus level decode.
module ctlbus_tx_fsm
    import ctlbus_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tmr_expired,
    input  logic last_bit,
    input  logic cur_bit,
    input  logic mode_q,
    output logic tmr_load,
    output logic tmr_sel_setup,
    output logic capture,
    output logic step,
    output logic busy,
    output logic done,
    output logic bus_mode,
    output logic bus_clk,
    output logic bus_dat
);

    tx_state_e state, state_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions and control strobes
    always_comb begin
        state_nxt     = state;
        tmr_load      = 1'b0;
        tmr_sel_setup = 1'b0;
        capture       = 1'b0;
        step          = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nxt     = ST_SETUP;
                    capture       = 1'b1;
                    tmr_load      = 1'b1;
                    tmr_sel_setup = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    state_nxt = ST_CLK_LO;
                    tmr_load  = 1'b1;
                end
            end
            ST_CLK_LO: begin
                if (tmr_expired) begin
                    state_nxt = ST_CLK_HI;
                    tmr_load  = 1'b1;
                end
            end
            ST_CLK_HI: begin
                if (tmr_expired) begin
                    if (last_bit) begin
                        state_nxt = ST_FINISH;
                    end else begin
                        state_nxt = ST_CLK_LO;
                        tmr_load  = 1'b1;
                        step      = 1'b1;
                    end
                end
            end
            ST_FINISH: begin
                state_nxt = ST_IDLE;
            end
            default: begin
                state_nxt = ST_IDLE;
            end
        endcase
    end

    // Output decode
    always_comb begin
        busy     = 1'b1;
        done     = 1'b0;
        bus_mode = 1'b1;
        bus_clk  = 1'b1;
        bus_dat  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_SETUP: begin
                bus_mode = mode_q;
            end
            ST_CLK_LO: begin
                bus_mode = mode_q;
                bus_clk  = 1'b0;
                bus_dat  = cur_bit;
            end
            ST_CLK_HI: begin
                bus_mode = mode_q;
                bus_dat  = cur_bit;
            end
            ST_FINISH: begin
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ctlbus_byte_tx.sv
module ctlbus_byte_tx #(
    parameter int SETUP_CYCLES = 48,
    parameter int HALF_CYCLES  = 4,
    parameter int DATA_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic [DATA_W-1:0] byte_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              bus_mode_o,
    output logic              bus_clk_o,
    output logic              bus_dat_o
);

    localparam int LONGEST = (SETUP_CYCLES > HALF_CYCLES) ? SETUP_CYCLES : HALF_CYCLES;
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam logic [CNT_W-1:0] SETUP_LOAD = CNT_W'(SETUP_CYCLES - 1);
    localparam logic [CNT_W-1:0] HALF_LOAD  = CNT_W'(HALF_CYCLES - 1);

    logic tmr_load, tmr_sel_setup, tmr_expired;
    logic capture, step, cur_bit, mode_q, last_bit;

    ctlbus_tx_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_sel_setup ? SETUP_LOAD : HALF_LOAD),
        .expired  (tmr_expired)
    );

    ctlbus_tx_shifter #(.NBITS(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .byte_in  (byte_i),
        .mode_in  (mode_i),
        .step     (step),
        .cur_bit  (cur_bit),
        .mode_q   (mode_q),
        .last_bit (last_bit)
    );

    ctlbus_tx_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start_i),
        .tmr_expired   (tmr_expired),
        .last_bit      (last_bit),
        .cur_bit       (cur_bit),
        .mode_q        (mode_q),
        .tmr_load      (tmr_load),
        .tmr_sel_setup (tmr_sel_setup),
        .capture       (capture),
        .step          (step),
        .busy          (busy_o),
        .done          (done_o),
        .bus_mode      (bus_mode_o),
        .bus_clk       (bus_clk_o),
        .bus_dat       (bus_dat_o)
    );

endmodule

// File: rtl/ctlbus_byte_tx_chk.sv
module ctlbus_byte_tx_chk #(
    parameter int SETUP_CYCLES = 48,
    parameter int DATA_W       = 8
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic bus_mode_o,
    input logic bus_clk_o,
    input logic bus_dat_o
);

    logic        clk_q;
    logic        seen_fall;
    int unsigned pre_cnt;
    int unsigned fall_cnt;
    logic        fall_now;

    assign fall_now = busy_o && !bus_clk_o && clk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q     <= 1'b1;
            seen_fall <= 1'b0;
            pre_cnt   <= 0;
            fall_cnt  <= 0;
        end else begin
            clk_q <= bus_clk_o;
            if (!busy_o) begin
                seen_fall <= 1'b0;
                pre_cnt   <= 0;
                fall_cnt  <= 0;
            end else begin
                if (!seen_fall && bus_clk_o) pre_cnt <= pre_cnt + 1;
                if (fall_now) begin
                    seen_fall <= 1'b1;
                    fall_cnt  <= fall_cnt + 1;
                end
            end
        end
    end

    a_r2_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (bus_mode_o && bus_clk_o && !bus_dat_o));

    a_r3_setup_levels: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (bus_clk_o && !bus_dat_o));

    a_r4_setup_time: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_now && !seen_fall) |-> (pre_cnt == SETUP_CYCLES));

    a_r5_eight_bits: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (fall_cnt == DATA_W));

    a_r6_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && bus_clk_o && $past(bus_clk_o) && !done_o)
        |-> $stable(bus_dat_o));

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_o && bus_mode_o && bus_clk_o && !bus_dat_o));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    a_r9_rise_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    a_r10_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !done_o) |-> $stable(bus_mode_o));

endmodule

bind ctlbus_byte_tx ctlbus_byte_tx_chk #(
    .SETUP_CYCLES (SETUP_CYCLES),
    .DATA_W       (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .bus_mode_o (bus_mode_o),
    .bus_clk_o  (bus_clk_o),
    .bus_dat_o  (bus_dat_o)
);

// File: tb/sim_ctlbus_byte_tx.sv
`timescale 1ns/1ps
module sim_ctlbus_byte_tx;

    localparam int S    = 48;
    localparam int H    = 4;
    localparam int DW   = 8;
    localparam int SPAN = 2 * H * DW;
    localparam int LAST = S + SPAN + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          mode_i = 1'b0;
    logic [DW-1:0] byte_i = '0;
    logic          busy_o, done_o, bus_mode_o, bus_clk_o, bus_dat_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int unsigned seed_sink;

    always #2 clk = ~clk;

    ctlbus_byte_tx #(.SETUP_CYCLES(S), .HALF_CYCLES(H), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .byte_i(byte_i), .busy_o(busy_o), .done_o(done_o),
        .bus_mode_o(bus_mode_o), .bus_clk_o(bus_clk_o), .bus_dat_o(bus_dat_o)
    );

    // Expected {busy, done, mode, clk, dat} in cycle t after acceptance
    function automatic logic [4:0] model(int t, logic [DW-1:0] b, logic m);
        int u;
        int idx;
        logic lowp;
        if (t <= S) return {1'b1, 1'b0, m, 1'b1, 1'b0};
        u = t - S - 1;
        if (u < SPAN) begin
            idx  = u / (2 * H);
            lowp = (u % (2 * H)) < H;
            return {1'b1, 1'b0, m, !lowp, b[idx]};
        end
        if (u == SPAN) return 5'b11110;
        return 5'b00110;
    endfunction

    function automatic string tag_of(int t);
        if (t <= S) return "R3 R4 R9";
        if (t - S - 1 < SPAN) return "R5 R6 R10";
        if (t - S - 1 == SPAN) return "R7 R8";
        return "R2 R9";
    endfunction

    task automatic check_bus(string tag, logic [4:0] exp);
        logic [4:0] got;
        got = {busy_o, done_o, bus_mode_o, bus_clk_o, bus_dat_o};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b (busy,done,mode,clk,dat) at %0t",
                     tag, got, exp, $time);
        end
    endtask

    task automatic run_xfer(logic [DW-1:0] b, logic m, bit noisy);
        @(negedge clk);
        start_i = 1'b1;
        byte_i  = b;
        mode_i  = m;
        @(negedge clk);
        start_i = 1'b0;
        for (int t = 1; t <= LAST; t++) begin
            check_bus(tag_of(t), model(t, b, m));
            if (noisy && t <= LAST - 1) begin
                start_i = 1'($urandom);
                byte_i  = DW'($urandom);
                mode_i  = 1'($urandom);
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            errors++;
            $display("FAIL watchdog: got no completion, expected finish within 200000 cycles");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        seed_sink = $urandom(32'd2741);
        repeat (3) @(negedge clk);
        check_bus("R1 reset", 5'b00110);
        rst_n = 1'b1;
        @(negedge clk);
        check_bus("R1 after reset", 5'b00110);
        // Idle with moving data inputs and no start: R2
        for (int i = 0; i < 4; i++) begin
            byte_i = DW'($urandom);
            mode_i = 1'($urandom);
            @(negedge clk);
            check_bus("R2 idle", 5'b00110);
        end
        // Directed corners
        run_xfer(8'h00, 1'b0, 1'b0);
        run_xfer(8'hFF, 1'b1, 1'b0);
        run_xfer(8'h01, 1'b0, 1'b0);
        run_xfer(8'h80, 1'b1, 1'b0);
        run_xfer(8'hA5, 1'b0, 1'b1);
        // Random transfers with noise on the inputs (R9, R10)
        for (int n = 0; n < 20; n++) begin
            run_xfer(DW'($urandom), 1'($urandom), 1'($urandom));
            repeat ($urandom % 3) begin
                check_bus("R2 gap", 5'b00110);
                @(negedge clk);
            end
        end
        // Back-to-back start right after the idle return
        run_xfer(8'h3C, 1'b1, 1'b1);
        run_xfer(8'hC3, 1'b0, 1'b0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule